// File: doc/BRIEF.md
# CAN Automatic Block Transmission Sequencer

This block sits next to a CAN transmit arbiter. It raises transmit requests for a fixed group of message buffers (buffers 0 to `NBUF-1`, eight by default) by itself, one buffer at a time and in rising buffer number. Software writes a start bit to launch a run and a rewind bit to send the position back to buffer 0. A delay register sets how many prescaled ticks pass between the completion of one group message and the request for the next. Buffers outside the group are requested by software and are not handled here.

The sequencer is a five-state machine:

- **IDLE**: stopped.
- **REQUEST**: checks that the current buffer is ready.
- **WAIT_COMPLETE**: holds the request until the arbiter reports completion.
- **DELAY**: counts delay ticks.
- **CLEARING**: one-cycle rewind.

The transitions are:

- **start**: IDLE→REQUEST, on the start bit when not in initialization mode.
- **rewind**: IDLE→CLEARING.
- **rewound**: CLEARING→IDLE.
- **issue**: REQUEST→WAIT_COMPLETE, when the buffer is ready.
- **stall**: REQUEST→IDLE, when the buffer is not ready. The position is kept.
- **advance**: WAIT_COMPLETE→REQUEST with a zero delay, or WAIT_COMPLETE→DELAY with a non-zero delay.
- **finish**: WAIT_COMPLETE→IDLE, after the last buffer. A done pulse is raised and the position wraps to 0.
- **expire**: DELAY→REQUEST.

Illegal software actions are ignored and reported as one-cycle error pulses.

Top module: `can_abt_seq`

## Requirements
- R1: After reset `run_flag` is 0, `pos` is 0, `tx_req` is all zero, and `rewind_busy`, `blk_done` and every error output are 0.
- R2: While running, `tx_req` has at most one bit set. Bit i stands for buffer i and equals the position `pos`. Buffers are requested in order 0,1,2,…, and the next request comes only after a `tx_done` pulse for the current one.
- R3: With `gap_cfg`=N>0, the next request does not appear before N `tick` pulses have followed the completion. It appears two cycles after the Nth tick pulse. With N=0 it appears two cycles after the completion.
- R4: A `rewind_req` pulse while `run_flag` is 0 makes `rewind_busy` 1 for exactly one cycle, starting the cycle after the pulse. After that cycle `pos` is 0.
- R5: A `rewind_req` while `run_flag` is 1 is ignored: `rewind_busy` stays 0 and the run goes on. `err_clr_run` pulses one cycle later.
- R6: A `trig_set` while `init_mode` is 1 is ignored: `run_flag` stays 0. `err_trig_init` pulses one cycle later.
- R7: While `run_flag` is 1, software request writes on `sw_req_set` are blocked from `tx_req` and `err_sw_req` pulses one cycle later. While `run_flag` is 0 they pass to `tx_req` in the same cycle.
- R8: A ready bit falling from 1 to 0 while `run_flag` is 1 raises `err_rdy_drop` one cycle later.
- R9: If the buffer at `pos` is not ready when its turn comes, the run stops: `run_flag` goes to 0 and `pos` keeps that buffer number. A later start resumes at that buffer.
- R10: After the last group buffer completes, `blk_done` is 1 for exactly one cycle. In that cycle `run_flag` is 0 and `pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Controller is in initialization mode |
| trig_set | input | 1 | Software writes 1 to the start bit |
| rewind_req | input | 1 | Software writes 1 to the rewind bit |
| gap_cfg | input | GAP_W | Delay, in ticks, between messages |
| tick | input | 1 | Prescaled delay tick |
| rdy | input | NBUF | Ready flag of each group buffer |
| sw_req_set | input | NBUF | Software transmit-request writes for group buffers |
| tx_done | input | 1 | Arbiter reports the requested message has completed |
| tx_req | output | NBUF | Transmit requests to the arbiter, bit i is buffer i |
| run_flag | output | 1 | Start bit readback: the sequence is running |
| rewind_busy | output | 1 | Rewind bit readback; clears by itself |
| pos | output | PTR_W | Current buffer position |
| blk_done | output | 1 | One-cycle pulse when the whole group has been sent |
| err_clr_run | output | 1 | Rewind attempted while running |
| err_trig_init | output | 1 | Start attempted in initialization mode |
| err_sw_req | output | 1 | Software request on a group buffer while running |
| err_rdy_drop | output | 1 | Ready flag cleared while running |

## Verification
A wrong state or position shows on `tx_req` at the next request. A skipped or repeated buffer produces the wrong one-hot bit within two cycles of the completion or final tick. A miscounted delay makes the request appear early or late against the tick count. A lost stall or a wrong wrap leaves `pos` or `run_flag` wrong in the cycle after the decision. Error and rewind pulses are checked in the cycle after the offending input, so any lost or added cycle of latency shows up at once.

// File: rtl/abt_pkg.sv
package abt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_CMPL,
        ST_DELAY,
        ST_CLEARING
    } abt_state_e;
endpackage

// File: rtl/abt_gap_timer.sv
module abt_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // final tick of a non-zero count
    assign expire = tick && (cnt == W'(1));
endmodule

// File: rtl/abt_fault_mon.sv
module abt_fault_mon #(
    parameter int NBUF = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            running,
    input  logic            init_mode,
    input  logic            trig_set,
    input  logic            rewind_req,
    input  logic [NBUF-1:0] sw_req_set,
    input  logic [NBUF-1:0] rdy,
    output logic            err_clr_run,
    output logic            err_trig_init,
    output logic            err_sw_req,
    output logic            err_rdy_drop
);
    logic [NBUF-1:0] rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q         <= '0;
            err_clr_run   <= 1'b0;
            err_trig_init <= 1'b0;
            err_sw_req    <= 1'b0;
            err_rdy_drop  <= 1'b0;
        end else begin
            rdy_q         <= rdy;
            err_clr_run   <= running && rewind_req;
            err_trig_init <= !running && init_mode && trig_set;
            err_sw_req    <= running && (sw_req_set != '0);
            err_rdy_drop  <= running && ((rdy_q & ~rdy) != '0);
        end
    end
endmodule

// File: rtl/can_abt_seq.sv
module can_abt_seq
    import abt_pkg::*;
#(
    parameter int NBUF  = 8,
    parameter int GAP_W = 8,
    parameter int PTR_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_mode,
    input  logic             trig_set,
    input  logic             rewind_req,
    input  logic [GAP_W-1:0] gap_cfg,
    input  logic             tick,
    input  logic [NBUF-1:0]  rdy,
    input  logic [NBUF-1:0]  sw_req_set,
    input  logic             tx_done,
    output logic [NBUF-1:0]  tx_req,
    output logic             run_flag,
    output logic             rewind_busy,
    output logic [PTR_W-1:0] pos,
    output logic             blk_done,
    output logic             err_clr_run,
    output logic             err_trig_init,
    output logic             err_sw_req,
    output logic             err_rdy_drop
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBUF - 1);

    abt_state_e       state, nxt;
    logic [PTR_W-1:0] ptr_r, ptr_nxt;
    logic             done_q, done_nxt;
    logic             gap_load, gap_expire;
    logic             running;

    abt_gap_timer #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_cfg),
        .tick     (tick),
        .expire   (gap_expire)
    );

    abt_fault_mon #(.NBUF(NBUF)) u_fault (
        .clk           (clk),
        .rst_n         (rst_n),
        .running       (running),
        .init_mode     (init_mode),
        .trig_set      (trig_set),
        .rewind_req    (rewind_req),
        .sw_req_set    (sw_req_set),
        .rdy           (rdy),
        .err_clr_run   (err_clr_run),
        .err_trig_init (err_trig_init),
        .err_sw_req    (err_sw_req),
        .err_rdy_drop  (err_rdy_drop)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr_r  <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            ptr_r  <= ptr_nxt;
            done_q <= done_nxt;
        end
    end

    // transitions
    always_comb begin
        nxt      = state;
        ptr_nxt  = ptr_r;
        done_nxt = 1'b0;
        gap_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rewind_req)                   nxt = ST_CLEARING;  // rewind
                else if (trig_set && !init_mode)  nxt = ST_REQUEST;   // start
            end
            ST_REQUEST: begin
                nxt = rdy[ptr_r] ? ST_WAIT_CMPL : ST_IDLE;            // issue / stall
            end
            ST_WAIT_CMPL: begin
                if (tx_done) begin
                    if (ptr_r == LAST) begin                          // finish
                        nxt      = ST_IDLE;
                        ptr_nxt  = '0;
                        done_nxt = 1'b1;
                    end else begin                                    // advance
                        ptr_nxt = ptr_r + 1'b1;
                        if (gap_cfg == '0) begin
                            nxt = ST_REQUEST;
                        end else begin
                            nxt      = ST_DELAY;
                            gap_load = 1'b1;
                        end
                    end
                end
            end
            ST_DELAY: begin
                if (gap_expire) nxt = ST_REQUEST;                     // expire
            end
            ST_CLEARING: begin
                nxt     = ST_IDLE;                                    // rewound
                ptr_nxt = '0;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running     = (state == ST_REQUEST) || (state == ST_WAIT_CMPL) ||
                      (state == ST_DELAY);
        rewind_busy = (state == ST_CLEARING);
        run_flag    = running;
        pos         = ptr_r;
        blk_done    = done_q;
        tx_req      = '0;
        if (state == ST_WAIT_CMPL) tx_req = NBUF'(1) << ptr_r;
        if (!running)              tx_req = sw_req_set;
    end
endmodule

// File: rtl/abt_seq_chk.sv
module abt_seq_chk #(
    parameter int NBUF  = 8,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_mode,
    input logic             trig_set,
    input logic             rewind_req,
    input logic [NBUF-1:0]  tx_req,
    input logic             run_flag,
    input logic             rewind_busy,
    input logic [PTR_W-1:0] pos,
    input logic             blk_done,
    input logic             err_clr_run,
    input logic             err_trig_init
);
    p_onehot_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_flag |-> $onehot0(tx_req));

    p_pos_rising_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_flag && $past(run_flag)) |-> (pos >= $past(pos)));

    p_busy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_busy |=> !rewind_busy);

    p_busy_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_busy |=> (pos == '0));

    p_clr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_req && run_flag) |=> (!rewind_busy && err_clr_run));

    p_trig_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_mode && trig_set && !run_flag) |=> (!run_flag && err_trig_init));

    p_done_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (!run_flag && pos == '0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);
endmodule

bind can_abt_seq abt_seq_chk #(.NBUF(NBUF), .PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_mode     (init_mode),
    .trig_set      (trig_set),
    .rewind_req    (rewind_req),
    .tx_req        (tx_req),
    .run_flag      (run_flag),
    .rewind_busy   (rewind_busy),
    .pos           (pos),
    .blk_done      (blk_done),
    .err_clr_run   (err_clr_run),
    .err_trig_init (err_trig_init)
);

// File: tb/can_abt_seq_bench.sv
module can_abt_seq_bench;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          init_mode, trig_set, rewind_req, tick, tx_done;
    logic [7:0]    gap_cfg;
    logic [NB-1:0] rdy, sw_req_set;
    logic [NB-1:0] tx_req;
    logic          run_flag, rewind_busy, blk_done;
    logic [2:0]    pos;
    logic          err_clr_run, err_trig_init, err_sw_req, err_rdy_drop;

    int nchk = 0;
    int nfail = 0;
    bit fin = 1'b0;

    always #2 clk = ~clk;

    can_abt_seq u_can_abt_seq (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .trig_set(trig_set),
        .rewind_req(rewind_req), .gap_cfg(gap_cfg), .tick(tick), .rdy(rdy),
        .sw_req_set(sw_req_set), .tx_done(tx_done), .tx_req(tx_req),
        .run_flag(run_flag), .rewind_busy(rewind_busy), .pos(pos),
        .blk_done(blk_done), .err_clr_run(err_clr_run),
        .err_trig_init(err_trig_init), .err_sw_req(err_sw_req),
        .err_rdy_drop(err_rdy_drop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] bufbit(input int k);
        return NB'(1) << k;
    endfunction

    function automatic int first_unready(input logic [NB-1:0] m, input int start);
        for (int i = start; i < NB; i++) if (!m[i]) return i;
        return NB;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_run();
        trig_set = 1'b1; cyc(1); trig_set = 1'b0;
    endtask

    task automatic serve(input int k, input int maxw);
        int w = 0;
        while (tx_req == '0 && w < maxw) begin cyc(1); w++; end
        chk($sformatf("R2 request for buffer %0d", k), 32'(tx_req), 32'(bufbit(k)));
        tx_done = 1'b1; cyc(1); tx_done = 1'b0;
    endtask

    task automatic gap_ticks(input int g);
        for (int i = 1; i <= g; i++) begin
            tick = 1'b1; cyc(1); tick = 1'b0;
            if (i < g) begin
                cyc(2);
                chk("R3 no request before all ticks", 32'(tx_req), 32'h0);
            end else begin
                chk("R3 no request on final tick cycle", 32'(tx_req), 32'h0);
            end
        end
    endtask

    task automatic run_seq(input int start, input int g, input bit do_start);
        if (do_start) start_run();
        for (int k = start; k < NB; k++) begin
            if (!rdy[k]) begin
                cyc(2);
                chk("R9 stall clears run flag", 32'(run_flag), 32'h0);
                chk("R9 stall keeps position", 32'(pos), 32'(k));
                chk("R9 no request after stall", 32'(tx_req), 32'h0);
                return;
            end
            serve(k, 2);
            if (k == NB - 1) begin
                chk("R10 done pulse", 32'(blk_done), 32'h1);
                chk("R10 run flag cleared", 32'(run_flag), 32'h0);
                chk("R10 position wrapped", 32'(pos), 32'h0);
                cyc(1);
                chk("R10 done lasts one cycle", 32'(blk_done), 32'h0);
                return;
            end
            gap_ticks(g);
        end
    endtask

    task automatic rewind();
        rewind_req = 1'b1; cyc(1); rewind_req = 1'b0;
        chk("R4 rewind busy", 32'(rewind_busy), 32'h1);
        cyc(1);
        chk("R4 rewind self-clears", 32'(rewind_busy), 32'h0);
        chk("R4 position home", 32'(pos), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; init_mode = 1'b0; trig_set = 1'b0; rewind_req = 1'b0;
        tick = 1'b0; tx_done = 1'b0; gap_cfg = 8'd0; rdy = '1; sw_req_set = '0;
        cyc(3);
        chk("R1 reset tx_req", 32'(tx_req), 32'h0);
        chk("R1 reset run flag", 32'(run_flag), 32'h0);
        chk("R1 reset pos", 32'(pos), 32'h0);
        chk("R1 reset flags", {27'h0, rewind_busy, blk_done, err_clr_run, err_trig_init,
            err_sw_req | err_rdy_drop}, 32'h0);
        rst_n = 1'b1; cyc(1);

        // full run, no gap
        run_seq(0, 0, 1'b1);
        // full run with gap
        gap_cfg = 8'd3;
        run_seq(0, 3, 1'b1);

        // stall at buffer 3, then resume there
        gap_cfg = 8'd0; rdy = 8'b1111_0111;
        run_seq(0, 0, 1'b1);
        rdy = '1;
        gap_cfg = 8'd1;
        run_seq(3, 1, 1'b1);

        // stall at 5, then rewind
        rdy = 8'b1101_1111; gap_cfg = 8'd0;
        run_seq(0, 0, 1'b1);
        rewind();

        // faults while running, parked in DELAY
        rdy = '1; gap_cfg = 8'd4;
        start_run();
        serve(0, 2);
        rewind_req = 1'b1; cyc(1); rewind_req = 1'b0;
        chk("R5 rewind error", 32'(err_clr_run), 32'h1);
        chk("R5 no rewind while running", 32'(rewind_busy), 32'h0);
        chk("R5 still running", 32'(run_flag), 32'h1);
        sw_req_set = 8'h80; #1;
        chk("R7 sw request blocked", 32'(tx_req), 32'h0);
        cyc(1); sw_req_set = '0;
        chk("R7 sw request error", 32'(err_sw_req), 32'h1);
        rdy = 8'hBF; cyc(1);
        chk("R8 ready drop error", 32'(err_rdy_drop), 32'h1);
        rdy = '1; cyc(1);
        chk("R8 no error on rise", 32'(err_rdy_drop), 32'h0);
        chk("R5 position kept", 32'(pos), 32'h1);
        gap_ticks(4);
        run_seq(1, 4, 1'b0);

        // start in init mode
        init_mode = 1'b1; trig_set = 1'b1; cyc(1); trig_set = 1'b0;
        chk("R6 init start error", 32'(err_trig_init), 32'h1);
        cyc(1);
        chk("R6 start ignored", 32'(run_flag), 32'h0);
        chk("R6 no request", 32'(tx_req), 32'h0);
        init_mode = 1'b0;

        // sw request pass-through while stopped
        sw_req_set = 8'h21; #1;
        chk("R7 sw request passes when stopped", 32'(tx_req), 32'h21);
        cyc(1); sw_req_set = '0;
        chk("R7 no error when stopped", 32'(err_sw_req), 32'h0);

        // random runs
        for (int r = 0; r < 8; r++) begin
            int g;
            logic [NB-1:0] m;
            int stop;
            rewind();
            g = int'($urandom % 4);
            m = NB'($urandom) | NB'($urandom);
            gap_cfg = 8'(g);
            rdy = m;
            cyc(1);
            stop = first_unready(m, 0);
            run_seq(0, g, 1'b1);
            if (stop < NB)
                chk("R9 random stall position", 32'(pos), 32'(stop));
            rdy = '1;
            cyc(1);
        end

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule